// File: doc/BRIEF.md
# Paired-Channel Routing Switch Matrix

This block is one routing switch of a small configurable fabric. Each of its four sides (north, east, south, west) has a group of short channels, which run to the adjacent switch, and a group of long channels, which run to the switch two rows or two columns away. Short channel `i` and long channel `i` form one fixed pair. A net keeps the same pair index across the whole fabric, so the switch only ever moves a signal between lanes that have the same index.

Every output lane (side, kind, index) has its own 3-bit source select. The select picks the short or long lane of the same index on one of the other three sides, or it drives a zero. All selects sit in one serial configuration chain. While `cfg_en` is high, the chain shifts one bit per clock. During that time every output is held at zero, so a partly loaded configuration never reaches the fabric. Once loading is complete, the path from the input lanes to the output lanes is purely combinational.

Top module: `sm_route_switch`

## Requirements
- R1: An active-low reset clears every select to code 0, so all outputs read zero after reset whatever the input lanes carry.
- R2: On each clock with `cfg_en` high, `cfg_din` enters chain bit 0 and every other chain bit moves up one position. After 3·8·N_CH shifts, the first bit shifted in sits at the top of the chain.
- R3: `cfg_dout` presents the top chain bit. Bits therefore leave the chain in the order they entered, one per shift, so switches can be daisy-chained.
- R4: Slot number f = (side·2 + kind)·N_CH + index selects chain bits [3f+2:3f], with side north=0, east=1, south=2, west=3 and kind short=0, long=1. Lane `side·N_CH + index` of `*_in`/`*_out` belongs to that side and index.
- R5: Select code s in 1..6 routes the source side (d + ((s−1)>>1) + 1) mod 4 for destination side d. It takes the long lane when (s−1) is odd and the short lane otherwise, and always uses the same index as the output lane.
- R6: Select codes 0 and 7 drive the output lane to zero.
- R7: An output lane of index i never depends on an input lane of any other index.
- R8: While `cfg_en` is high, every output lane is zero.
- R9: With `cfg_en` low, an output follows a change of its selected input without waiting for a clock edge.
- R10: While `cfg_en` is low, `cfg_din` has no effect. The stored configuration and `cfg_dout` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration chain clock |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| cfg_en | input | 1 | Shift enable; also blanks all outputs |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output (top chain bit) |
| short_in | input | 4·N_CH | Short lanes arriving, lane side·N_CH+index |
| long_in | input | 4·N_CH | Long lanes arriving, lane side·N_CH+index |
| short_out | output | 4·N_CH | Short lanes leaving |
| long_out | output | 4·N_CH | Long lanes leaving |

## Verification
The bench builds the switch with the default N_CH = 4, which gives 32 selects and a 96-bit chain. At this size every select code, every side rotation and every pair index is within reach of random configurations, and a whole reload takes only 96 clocks. Each reload also shifts the previous configuration out, so `cfg_dout` is compared bit by bit with the configuration the bench last loaded. Directed loads cover a single isolated slot, an all-code-7 chain, reset in the middle of operation, and input changes between clock edges.

// File: rtl/sm_route_pkg.sv
package sm_route_pkg;

    // Fixed geometry of one switch: four sides, two channel kinds.
    localparam int NUM_SIDES = 4;
    localparam int NUM_KINDS = 2;
    localparam int SEL_W     = 3;
    // Candidate sources per output: other three sides times two kinds.
    localparam int SRC_CNT   = (NUM_SIDES - 1) * NUM_KINDS;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef enum logic {
        KIND_SHORT = 1'b0,
        KIND_LONG  = 1'b1
    } kind_e;

    // Slot number of a select inside the configuration chain.
    function automatic int sel_slot(input int side, input int kind,
                                    input int idx, input int n_ch);
        return (side * NUM_KINDS + kind) * n_ch + idx;
    endfunction

    // Source side reached by candidate j from destination side d.
    function automatic int src_side(input int d, input int j);
        return (d + (j / NUM_KINDS) + 1) % NUM_SIDES;
    endfunction

    // Channel kind taken by candidate j.
    function automatic int src_kind(input int j);
        return j % NUM_KINDS;
    endfunction

endpackage

// File: rtl/sm_cfg_chain.sv
module sm_cfg_chain #(
    parameter int CHAIN_W = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [CHAIN_W-1:0] bits,
    output logic               dout
);

    typedef struct packed {
        logic [CHAIN_W-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    // Next-state: shift toward the top when enabled, otherwise hold.
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {st_q.bits[CHAIN_W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
    assign dout = st_q.bits[CHAIN_W-1];

endmodule

// File: rtl/sm_chan_mux.sv
module sm_chan_mux #(
    parameter int SEL_W   = 3,
    parameter int SRC_CNT = 6
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [SRC_CNT-1:0] cand,
    input  logic               blank,
    output logic               y
);

    // Code 0 and any code above SRC_CNT leave the lane undriven (zero).
    always_comb begin
        y = 1'b0;
        if (!blank) begin
            for (int j = 0; j < SRC_CNT; j++) begin
                if (sel == SEL_W'(j + 1)) begin
                    y = cand[j];
                end
            end
        end
    end

endmodule

// File: rtl/sm_route_switch.sv
module sm_route_switch
    import sm_route_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en,
    input  logic                      cfg_din,
    output logic                      cfg_dout,
    input  logic [NUM_SIDES*N_CH-1:0] short_in,
    input  logic [NUM_SIDES*N_CH-1:0] long_in,
    output logic [NUM_SIDES*N_CH-1:0] short_out,
    output logic [NUM_SIDES*N_CH-1:0] long_out
);

    localparam int LANES    = NUM_SIDES * N_CH;
    localparam int SLOTS    = NUM_SIDES * NUM_KINDS * N_CH;
    localparam int CFG_BITS = SLOTS * SEL_W;

    logic [CFG_BITS-1:0] cfg_bits;

    // Serial configuration store.
    sm_cfg_chain #(
        .CHAIN_W (CFG_BITS)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .bits     (cfg_bits),
        .dout     (cfg_dout)
    );

    // One multiplexer per (side, kind, index); candidates share the index.
    for (genvar d = 0; d < NUM_SIDES; d++) begin : g_side
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            for (genvar i = 0; i < N_CH; i++) begin : g_idx
                localparam int SLOT = sel_slot(d, k, i, N_CH);
                localparam int LANE = d * N_CH + i;

                logic [SRC_CNT-1:0] cand;
                logic               lane_y;

                for (genvar j = 0; j < SRC_CNT; j++) begin : g_cand
                    localparam int SRC_LANE = src_side(d, j) * N_CH + i;
                    if (src_kind(j) == int'(KIND_LONG)) begin : g_long
                        assign cand[j] = long_in[SRC_LANE];
                    end else begin : g_short
                        assign cand[j] = short_in[SRC_LANE];
                    end
                end

                sm_chan_mux #(
                    .SEL_W   (SEL_W),
                    .SRC_CNT (SRC_CNT)
                ) u_mux (
                    .sel   (cfg_bits[SLOT*SEL_W +: SEL_W]),
                    .cand  (cand),
                    .blank (cfg_en),
                    .y     (lane_y)
                );

                if (k == int'(KIND_LONG)) begin : g_to_long
                    assign long_out[LANE] = lane_y;
                end else begin : g_to_short
                    assign short_out[LANE] = lane_y;
                end
            end
        end
    end

endmodule

// File: rtl/sm_route_switch_chk.sv
module sm_route_switch_chk #(
    parameter int N_CH = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_en,
    input logic                      cfg_din,
    input logic                      cfg_dout,
    input logic [4*N_CH-1:0]         short_in,
    input logic [4*N_CH-1:0]         long_in,
    input logic [4*N_CH-1:0]         short_out,
    input logic [4*N_CH-1:0]         long_out,
    input logic [4*2*N_CH*3-1:0]     cfg_bits
);

    localparam int CFG_BITS = 4 * 2 * N_CH * 3;

    // Per-index activity summaries across all sides.
    logic [N_CH-1:0] idx_in_any;
    logic [N_CH-1:0] idx_out_any;

    always_comb begin
        idx_in_any  = '0;
        idx_out_any = '0;
        for (int i = 0; i < N_CH; i++) begin
            for (int s = 0; s < 4; s++) begin
                idx_in_any[i]  = idx_in_any[i]  | short_in[s*N_CH+i]  | long_in[s*N_CH+i];
                idx_out_any[i] = idx_out_any[i] | short_out[s*N_CH+i] | long_out[s*N_CH+i];
            end
        end
    end

    AST_LOAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (short_out == '0 && long_out == '0)); // R8

    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_bits == {$past(cfg_bits[CFG_BITS-2:0]), $past(cfg_din)}); // R2

    AST_DOUT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_dout == $past(cfg_bits[CFG_BITS-2])); // R3

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> ($stable(cfg_bits) && $stable(cfg_dout))); // R10

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits == '0) |-> (short_out == '0 && long_out == '0)); // R6

    for (genvar i = 0; i < N_CH; i++) begin : g_lock
        AST_INDEX_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            !idx_in_any[i] |-> !idx_out_any[i]); // R7
    end

endmodule

bind sm_route_switch sm_route_switch_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_din   (cfg_din),
    .cfg_dout  (cfg_dout),
    .short_in  (short_in),
    .long_in   (long_in),
    .short_out (short_out),
    .long_out  (long_out),
    .cfg_bits  (cfg_bits)
);

// File: tb/test_sm_route_switch.sv
module test_sm_route_switch;

    localparam int N     = 4;
    localparam int LANES = 4 * N;
    localparam int SLOTS = 8 * N;
    localparam int CB    = SLOTS * 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0;
    logic             cfg_din = 1'b0;
    logic             cfg_dout;
    logic [LANES-1:0] short_in = '0;
    logic [LANES-1:0] long_in = '0;
    logic [LANES-1:0] short_out;
    logic [LANES-1:0] long_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [CB-1:0] model = '0;
    logic [CB-1:0] next_cfg;

    always #10 clk = ~clk;  // 50 MHz

    sm_route_switch #(.N_CH(N)) i_sm_route_switch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_din   (cfg_din),
        .cfg_dout  (cfg_dout),
        .short_in  (short_in),
        .long_in   (long_in),
        .short_out (short_out),
        .long_out  (long_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected lane value from the requirement formulas (R4, R5, R6).
    function automatic logic exp_lane(input logic [CB-1:0] m, input int kind, input int d,
                                      input int i, input logic [LANES-1:0] si,
                                      input logic [LANES-1:0] li);
        int f = (d * 2 + kind) * N + i;
        logic [2:0] s = m[3*f +: 3];
        int off, sk, src;
        if (s == 3'd0 || s == 3'd7) return 1'b0;
        off = ((int'(s) - 1) >> 1) + 1;
        sk  = (int'(s) - 1) & 1;
        src = (d + off) % 4;
        return sk ? li[src*N+i] : si[src*N+i];
    endfunction

    function automatic logic [LANES-1:0] exp_vec(input int kind);
        logic [LANES-1:0] v;
        for (int d = 0; d < 4; d++)
            for (int i = 0; i < N; i++)
                v[d*N+i] = exp_lane(model, kind, d, i, short_in, long_in);
        return v;
    endfunction

    task automatic check_outs(input string tag);
        check({tag, " short_out"}, 32'(short_out), 32'(exp_vec(0)));
        check({tag, " long_out"},  32'(long_out),  32'(exp_vec(1)));
    endtask

    task automatic rand_inputs();
        short_in = LANES'($urandom);
        long_in  = LANES'($urandom);
    endtask

    // Shift next_cfg in, top bit first; old contents stream out of cfg_dout.
    task automatic load_cfg();
        logic [CB-1:0] old = model;
        for (int k = 0; k < CB; k++) begin
            @(negedge clk);
            check("R3 cfg_dout order", 32'(cfg_dout), 32'(old[CB-1-k]));
            cfg_en  = 1'b1;
            cfg_din = next_cfg[CB-1-k];
            rand_inputs();
            #1;
            check("R8 blank during load", 32'({short_out, long_out}), 32'd0);
        end
        @(negedge clk);
        cfg_en = 1'b0;
        model  = next_cfg;
        #1;
        check("R3 cfg_dout top after load", 32'(cfg_dout), 32'(model[CB-1]));
    endtask

    task automatic rand_cfg();
        for (int f = 0; f < SLOTS; f++) next_cfg[3*f +: 3] = 3'($urandom_range(7, 0));
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd5021));
        // R1: reset state
        rand_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int t = 0; t < 5; t++) begin
            rand_inputs();
            #1;
            check("R1 outputs after reset", 32'({short_out, long_out}), 32'd0);
            check("R1 cfg_dout after reset", 32'(cfg_dout), 32'd0);
        end

        // R4/R5 directed: east long index 2 takes code 3 -> west short index 2
        next_cfg = '0;
        next_cfg[3*((1*2+1)*N+2) +: 3] = 3'd3;
        load_cfg();
        short_in = '0; long_in = '0;
        short_in[3*N+2] = 1'b1;
        #1;
        check("R4 single slot long_out", 32'(long_out), 32'(16'h0001 << (1*N+2)));
        check("R4 single slot short_out", 32'(short_out), 32'd0);
        short_in = '0; long_in = '1; short_in[3*N+2] = 1'b0;
        #1;
        check("R5 source kind short only", 32'(long_out), 32'd0);

        // R6: all selects code 7
        next_cfg = '1;
        load_cfg();
        for (int t = 0; t < 8; t++) begin
            rand_inputs();
            #1;
            check("R6 code 7 is zero", 32'({short_out, long_out}), 32'd0);
        end

        // R5/R7: random configurations and random inputs
        for (int c = 0; c < 6; c++) begin
            rand_cfg();
            load_cfg();
            for (int t = 0; t < 20; t++) begin
                @(negedge clk);
                rand_inputs();
                #1;
                check_outs("R5 R7 random routing");
            end
            // R9: changes between edges propagate without a clock
            @(negedge clk);
            rand_inputs();
            #2;
            check_outs("R9 combinational path a");
            short_in = ~short_in;
            long_in  = ~long_in;
            #2;
            check_outs("R9 combinational path b");
        end

        // R10: cfg_din ignored while cfg_en is low
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
            rand_inputs();
            #1;
            check_outs("R10 config held");
            check("R10 cfg_dout held", 32'(cfg_dout), 32'(model[CB-1]));
        end

        // R2: a further load streams the held config out unchanged
        rand_cfg();
        load_cfg();
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            rand_inputs();
            #1;
            check_outs("R2 chain contents");
        end

        // R1: reset in mid-operation clears the configuration
        rst_n = 1'b0;
        model = '0;
        #1;
        check("R1 mid reset outputs", 32'({short_out, long_out}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            rand_inputs();
            #1;
            check("R1 after mid reset", 32'({short_out, long_out}), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule